// File: doc/BRIEF.md
# Configuration Space Address/Data Port Translator

This block sits on the host side of a bridge and gives a processor two 32-bit I/O ports for reaching device configuration space. A write to the address port (I/O 0xCF8) loads a selector register that holds an enable flag, a bus number, a device number, a function number and a dword index. An access to the data port (I/O 0xCFC) becomes one configuration transaction toward the downstream side, provided the enable flag is set. The transaction carries the selector fields, the processor's byte enables and, for writes, its data.

The processor side uses valid/ready. The requester raises `cpu_valid` and holds the address, direction, byte enables and write data unchanged until it samples `cpu_ready` high on a rising edge. That edge completes the access. For reads, `cpu_rdata` is valid in the same cycle. Accesses that need no downstream work are accepted in the cycle they are presented. The downstream side uses request/done. `cfg_req` stays high, with its fields held, until the responder pulses `cfg_done`, or until a fixed timeout expires.

A target that does not claim the access, or a responder that never answers, completes the access without any error indication. Reads then return all ones and write data is dropped.

Top module: `cfgx_bridge`

## Requirements
- R1: After reset the selector register is zero. Reading 0xCF8 returns 0x00000000 and `cfg_req` is low.
- R2: A write to 0xCF8 loads the selector, with bit 31 as enable, bits 23..16 as bus, bits 15..11 as device, bits 10..8 as function and bits 7..2 as dword index. A read of 0xCF8 returns the stored value with bits 1..0 forced to zero.
- R3: Any access to 0xCF8, and any access to an address that is neither port, completes in the cycle it is presented (`cpu_ready` high together with `cpu_valid`) and raises no `cfg_req`. Unmapped reads return 0xFFFFFFFF.
- R4: While the enable bit is 0, a data-port read returns 0xFFFFFFFF, a data-port write is dropped, and no `cfg_req` is raised.
- R5: With enable set, a data-port access raises `cfg_req` in the next cycle. The request carries bus, device, function and dword index from the selector, `cfg_be` equal to `cpu_be` unchanged, `cfg_we` equal to `cpu_we`, and `cfg_wdata` equal to `cpu_wdata`.
- R6: While `cfg_req` is high and the access has not completed, `cpu_ready` is low and the request fields stay stable.
- R7: When `cfg_done` comes with `cfg_claimed` high on a read, `cpu_rdata` equals `cfg_rdata` unchanged. Byte lane 0 is bits 7..0, so a 16-bit field at an offset with bit 1 set is bits 31..16.
- R8: When `cfg_done` comes with `cfg_claimed` low, the access completes in that cycle. A read returns 0xFFFFFFFF.
- R9: If no `cfg_done` arrives, the access completes in the 16th cycle of `cfg_req` (TIMEOUT) with read data 0xFFFFFFFF.
- R10: A `cfg_done` that arrives in the final timeout cycle takes precedence: claimed read data is returned.
- R11: `cfg_req` is low in the cycle after the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | I/O access presented |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | I/O address |
| cpu_be | input | 4 | Byte enables, bit n = byte lane n |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access completes on this edge |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cfg_req | output | 1 | Configuration transaction pending |
| cfg_we | output | 1 | Transaction direction |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_fn | output | 3 | Function number |
| cfg_dword | output | 6 | Dword index in configuration space |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cfg_done | input | 1 | Responder finished the transaction |
| cfg_claimed | input | 1 | A target claimed it (valid with cfg_done) |
| cfg_rdata | input | 32 | Read data (valid with cfg_done) |

## Verification
The timeout expiry and a responder's completion can land in the same cycle. The bench provokes this by setting its downstream model to answer exactly in the 16th request cycle with a claimed read carrying a distinctive pattern. The result is judged at the processor port: that pattern must come back rather than all ones, and the request must have been held for exactly 16 cycles. A late responder that misses this cycle is run as a separate case and must produce all ones.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  typedef struct packed {
    logic       en;
    logic [6:0] rsvd;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dword;
    logic [1:0] zero;
  } sel_t;

  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;
endpackage

// File: rtl/cfgx_sel_reg.sv
module cfgx_sel_reg
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [31:0] d,
  output sel_t        q
);
  logic [31:2] r;

  always_ff @(posedge clk) begin
    if (!rst_n)  r <= '0;
    else if (ld) r <= d[31:2];
  end

  assign q = sel_t'({r, 2'b00});
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic busy,
  output logic expire
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign expire  = busy && at_last && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done || at_last) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge
  import cfgx_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [15:0] SEL_PORT  = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  parameter int          TIMEOUT   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [3:0]    cpu_be,
  input  logic [31:0]   cpu_wdata,
  output logic          cpu_ready,
  output logic [31:0]   cpu_rdata,
  output logic          cfg_req,
  output logic          cfg_we,
  output logic [7:0]    cfg_bus,
  output logic [4:0]    cfg_dev,
  output logic [2:0]    cfg_fn,
  output logic [5:0]    cfg_dword,
  output logic [3:0]    cfg_be,
  output logic [31:0]   cfg_wdata,
  input  logic          cfg_done,
  input  logic          cfg_claimed,
  input  logic [31:0]   cfg_rdata
);
  sel_t sel;
  logic hit_sel, hit_data, start, busy, expire, sel_ld;

  assign hit_sel  = (cpu_addr == AW'(SEL_PORT));
  assign hit_data = (cpu_addr == AW'(DATA_PORT));
  assign start    = !busy && cpu_valid && hit_data && sel.en;
  assign sel_ld   = !busy && cpu_valid && hit_sel && cpu_we;

  cfgx_sel_reg u_sel (
    .clk (clk),
    .rst_n (rst_n),
    .ld (sel_ld),
    .d (cpu_wdata),
    .q (sel)
  );

  cfgx_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk (clk),
    .rst_n (rst_n),
    .start (start),
    .done (cfg_done),
    .busy (busy),
    .expire (expire)
  );

  always_comb begin
    if (!busy) begin
      cpu_ready = cpu_valid && !start;
      cpu_rdata = hit_sel ? 32'(sel) : ALL_ONES;
    end else begin
      cpu_ready = cfg_done || expire;
      cpu_rdata = (cfg_done && cfg_claimed && !cpu_we) ? cfg_rdata : ALL_ONES;
    end
  end

  assign cfg_req   = busy;
  assign cfg_we    = cpu_we;
  assign cfg_bus   = sel.bus;
  assign cfg_dev   = sel.dev;
  assign cfg_fn    = sel.fn;
  assign cfg_dword = sel.dword;
  assign cfg_be    = cpu_be;
  assign cfg_wdata = cpu_wdata;
endmodule

// File: rtl/cfgx_bridge_chk.sv
module cfgx_bridge_chk #(
  parameter int TIMEOUT = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic        cpu_we,
  input logic        cpu_ready,
  input logic [31:0] cpu_rdata,
  input logic [3:0]  cpu_be,
  input logic        cfg_req,
  input logic        cfg_we,
  input logic [7:0]  cfg_bus,
  input logic [4:0]  cfg_dev,
  input logic [2:0]  cfg_fn,
  input logic [5:0]  cfg_dword,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic        cfg_done,
  input logic        cfg_claimed,
  input logic [31:0] sel_q
);
  int reqcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       reqcnt <= 0;
    else if (cfg_req) reqcnt <= reqcnt + 1;
    else              reqcnt <= 0;
  end

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[1:0] == 2'b00);

  a_r5_fields_from_sel: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_bus == sel_q[23:16] && cfg_dev == sel_q[15:11] &&
                 cfg_fn == sel_q[10:8] && cfg_dword == sel_q[7:2] &&
                 cfg_be == cpu_be));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cpu_ready) |=> (cfg_req && $stable(cfg_bus) && $stable(cfg_dev) &&
      $stable(cfg_fn) && $stable(cfg_dword) && $stable(cfg_be) &&
      $stable(cfg_we) && $stable(cfg_wdata)));

  a_r8_unclaimed_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_done && !cfg_claimed && !cfg_we) |-> (cpu_ready && cpu_rdata == 32'hFFFF_FFFF));

  a_r9_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (reqcnt < TIMEOUT));

  a_r11_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cpu_ready) |=> !cfg_req);

  a_r3_valid_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cfg_req) |-> cpu_valid);
endmodule

bind cfgx_bridge cfgx_bridge_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_we (cpu_we),
  .cpu_ready (cpu_ready),
  .cpu_rdata (cpu_rdata),
  .cpu_be (cpu_be),
  .cfg_req (cfg_req),
  .cfg_we (cfg_we),
  .cfg_bus (cfg_bus),
  .cfg_dev (cfg_dev),
  .cfg_fn (cfg_fn),
  .cfg_dword (cfg_dword),
  .cfg_be (cfg_be),
  .cfg_wdata (cfg_wdata),
  .cfg_done (cfg_done),
  .cfg_claimed (cfg_claimed),
  .sel_q (32'(sel))
);

// File: tb/cfgx_bridge_tb.sv
module cfgx_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SELP = 16'h0CF8;
  localparam logic [15:0] DATP = 16'h0CFC;

  logic        clk = 0, rst_n = 0;
  logic        cpu_valid = 0, cpu_we = 0;
  logic [15:0] cpu_addr = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        cfg_req, cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_dword;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_done = 0, cfg_claimed = 0;
  logic [31:0] cfg_rdata = '0;

  int checks = 0, failures = 0;
  bit finished = 0;

  // downstream model controls and captures
  bit          rsp_en = 0, rsp_claim = 0;
  int          rsp_delay = 0, rcnt = 0, reqcyc = 0, unstable = 0;
  logic [31:0] rsp_data = '0;
  logic [7:0]  c_bus; logic [4:0] c_dev; logic [2:0] c_fn; logic [5:0] c_dw;
  logic [3:0]  c_be;  logic [31:0] c_wd; logic c_we;

  cfgx_bridge u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (cfg_req) begin
      if (reqcyc > 0 && {c_bus, c_dev, c_fn, c_dw, c_be, c_wd, c_we} !=
          {cfg_bus, cfg_dev, cfg_fn, cfg_dword, cfg_be, cfg_wdata, cfg_we}) unstable++;
      {c_bus, c_dev, c_fn, c_dw, c_be, c_wd, c_we} =
        {cfg_bus, cfg_dev, cfg_fn, cfg_dword, cfg_be, cfg_wdata, cfg_we};
      if (rsp_en && rcnt == rsp_delay) begin
        cfg_done = 1; cfg_claimed = rsp_claim; cfg_rdata = rsp_data;
      end else cfg_done = 0;
      rcnt++; reqcyc++;
    end else begin
      cfg_done = 0; rcnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_io(input logic we, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    reqcyc = 0; unstable = 0;
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    waits = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1; waits++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_valid = 0;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] rd; int w;
    chk("R1 cfg_req after reset", 32'(cfg_req), 0);
    cpu_io(0, SELP, 4'hF, 0, rd, w);
    chk("R1 selector reads zero", rd, 0);
  endtask

  task automatic t_sel_reg;
    logic [31:0] rd; int w;
    cpu_io(1, SELP, 4'hF, 32'h8012_AB07, rd, w);
    chk("R3 selector write zero wait", 32'(w), 0);
    cpu_io(0, SELP, 4'hF, 0, rd, w);
    chk("R2 selector readback low bits zero", rd, 32'h8012_AB04);
    chk("R3 selector access no request", 32'(reqcyc), 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] rd; int w;
    cpu_io(0, 16'h0080, 4'hF, 0, rd, w);
    chk("R3 unmapped read ones", rd, 32'hFFFF_FFFF);
    chk("R3 unmapped zero wait", 32'(w), 0);
    chk("R3 unmapped no request", 32'(reqcyc), 0);
  endtask

  task automatic t_disabled;
    logic [31:0] rd; int w;
    cpu_io(1, SELP, 4'hF, 32'h0012_3408, rd, w);
    cpu_io(0, DATP, 4'hF, 0, rd, w);
    chk("R4 disabled read ones", rd, 32'hFFFF_FFFF);
    chk("R4 disabled read no request", 32'(reqcyc), 0);
    cpu_io(1, DATP, 4'hF, 32'h5555_AAAA, rd, w);
    chk("R4 disabled write no request", 32'(reqcyc), 0);
    chk("R4 disabled write zero wait", 32'(w), 0);
  endtask

  task automatic t_claimed_read;
    logic [31:0] rd; int w;
    cpu_io(1, SELP, 4'hF, 32'h8005_1A08, rd, w);
    rsp_en = 1; rsp_claim = 1; rsp_delay = 2; rsp_data = 32'h1234_ABCD;
    cpu_io(0, DATP, 4'hF, 0, rd, w);
    chk("R5 bus", 32'(c_bus), 5);
    chk("R5 device", 32'(c_dev), 3);
    chk("R5 function", 32'(c_fn), 2);
    chk("R5 dword", 32'(c_dw), 2);
    chk("R5 read direction", 32'(c_we), 0);
    chk("R7 claimed read data", rd, 32'h1234_ABCD);
    chk("R7 upper half field", rd >> 16, 32'h1234);
    chk("R6 request cycles", 32'(reqcyc), 3);
    chk("R6 fields stable", 32'(unstable), 0);
    chk("R11 request dropped", 32'(cfg_req), 0);
  endtask

  task automatic t_claimed_write;
    logic [31:0] rd; int w;
    rsp_en = 1; rsp_claim = 1; rsp_delay = 0;
    cpu_io(1, DATP, 4'b0110, 32'hDEAD_0BEE, rd, w);
    chk("R5 byte enables pass", 32'(c_be), 32'h6);
    chk("R5 write data", c_wd, 32'hDEAD_0BEE);
    chk("R5 write direction", 32'(c_we), 1);
    chk("R6 one request cycle", 32'(reqcyc), 1);
    chk("R11 request dropped", 32'(cfg_req), 0);
  endtask

  task automatic t_unclaimed;
    logic [31:0] rd; int w;
    rsp_en = 1; rsp_claim = 0; rsp_delay = 1; rsp_data = 32'h0BAD_0BAD;
    cpu_io(0, DATP, 4'hF, 0, rd, w);
    chk("R8 unclaimed read ones", rd, 32'hFFFF_FFFF);
    chk("R8 completes on done", 32'(reqcyc), 2);
    cpu_io(1, DATP, 4'hF, 32'h1111_2222, rd, w);
    chk("R8 unclaimed write completes", 32'(reqcyc), 2);
  endtask

  task automatic t_timeout;
    logic [31:0] rd; int w;
    rsp_en = 0;
    cpu_io(0, DATP, 4'hF, 0, rd, w);
    chk("R9 timeout read ones", rd, 32'hFFFF_FFFF);
    chk("R9 timeout request cycles", 32'(reqcyc), 16);
    chk("R11 request dropped after timeout", 32'(cfg_req), 0);
  endtask

  task automatic t_done_at_limit;
    logic [31:0] rd; int w;
    rsp_en = 1; rsp_claim = 1; rsp_delay = 15; rsp_data = 32'hCAFE_F00D;
    cpu_io(0, DATP, 4'hF, 0, rd, w);
    chk("R10 done in last cycle wins", rd, 32'hCAFE_F00D);
    chk("R10 request cycles", 32'(reqcyc), 16);
    rsp_delay = 16;
    cpu_io(0, DATP, 4'hF, 0, rd, w);
    chk("R9 late done ignored", rd, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_sel_reg;
    t_unmapped;
    t_disabled;
    t_claimed_read;
    t_claimed_write;
    t_unclaimed;
    t_timeout;
    t_done_at_limit;
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule